// File: doc/BRIEF.md
# Tuning Bus Master

This block drives a shared three-wire serial bus that programs several digitally tuned capacitor devices. All devices listen on one serial clock line and one serial data line. Each device also has a private enable line that works as its chip select. A client hands over one request at a time through a valid/ready handshake. The request carries a device index, a 5-bit tuning state and a standby flag. The master builds an 8-bit word and raises only the chosen device's enable. It then shifts the word out most significant bit first, one bit per serial clock rising edge. Finally it lowers the enable, and the addressed device commits the word on that falling edge.

Every bus timing interval is counted in system clock cycles, and each count is a parameter. The intervals are the serial clock half-period, the lead from the enable rising to the first clock rising edge, the extra trail after the last clock high phase, and the quiet gap between words. The parameters are sized so that each interval meets the devices' minimum timing at the chosen system clock. Transfers are strictly sequential, so the devices change state one after another in the order they were requested.

The controller is one state machine with six states:
- IDLE: ready is high.
- LEAD: the enable is high and the clock is low.
- SCK_HI and SCK_LO: the two serial clock phases.
- TAIL: the clock is low after the eighth high phase.
- GAP: all enables are low and the master waits.

The transitions are:
- IDLE→LEAD when a request is accepted.
- LEAD→SCK_HI when the lead count expires.
- SCK_HI→SCK_LO after the high count, while bits remain.
- SCK_LO→SCK_HI after the low count.
- SCK_HI→TAIL after the eighth high phase.
- TAIL→GAP when the trail count expires.
- GAP→IDLE when the gap count expires.

Top module: `tune_bus_master`

## Requirements
- R1: At most one enable line is high at any time. During a transfer for index d < NUM_DEV, only bit d of `bus_sen` rises and all other bits stay low.
- R2: Each transfer has exactly 8 serial clock rising edges. The data bits sampled on those edges, in order, form the word {0, 0, standby, state[4:0]}, with bit 7 first and bit 0 last.
- R3: The data line never changes during a cycle in which the serial clock is high. It changes only together with a clock falling edge, or when an enable rises or falls.
- R4: Every serial clock high phase lasts HALF_CYC cycles. Consecutive rising edges within a word are 2*HALF_CYC cycles apart.
- R5: The first serial clock rising edge comes LEAD_CYC cycles after the enable rises. The enable rises on the clock edge that accepts the request.
- R6: The enable falls HALF_CYC+TRAIL_CYC cycles after the last serial clock rising edge.
- R7: After the enable falls, all enables stay low for at least GAP_CYC cycles. `req_ready` returns exactly GAP_CYC cycles after the fall.
- R8: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low in the cycle after acceptance. With `req_valid` low, no transfer starts.
- R9: While `req_ready` is high, and during reset, the serial clock, the data line and all enables are low.
- R10: A request whose index is NUM_DEV or above is accepted and runs the full timed sequence, but no enable line rises.
- R11: Requests issued in turn to different devices commit in request order, each when its own enable falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Master idle, can accept a request |
| req_dev | input | DEV_W | Target device index |
| req_state | input | 5 | Tuning state to program |
| req_standby | input | 1 | Standby flag (1 = low-current standby) |
| bus_sclk | output | 1 | Shared serial clock, idles low |
| bus_sdata | output | 1 | Shared serial data, idles low |
| bus_sen | output | NUM_DEV | Per-device enable lines |

## Verification
The bound checker watches these properties on every cycle:
- the one-hot limit on the enables;
- the data line held still while the clock is high;
- the width of each high phase and the low-phase spacing;
- the lead, trail and inter-word gap lengths;
- ready falling after acceptance;
- quiet outputs while idle.

Only the bench's scenarios show the rest:
- that the shifted bits form the right word for every state and standby value;
- that the correct device's line is the one raised;
- that an out-of-range index keeps every enable low for a whole transfer;
- that a run of requests to different devices commits in order.

// File: rtl/tbm_pkg.sv
package tbm_pkg;

    localparam int WORD_W  = 8;
    localparam int TUNE_W  = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SCK_HI,
        ST_SCK_LO,
        ST_TAIL,
        ST_GAP
    } tbm_state_e;

    // Word layout: two reserved zeros, standby flag, then tuning state.
    function automatic logic [WORD_W-1:0] build_word(input logic standby,
                                                     input logic [TUNE_W-1:0] tune);
        return {2'b00, standby, tune};
    endfunction

    function automatic int max4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/tbm_phase_timer.sv
module tbm_phase_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val - 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/tbm_word_shifter.sv
module tbm_word_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] word,
    input  logic              shift,
    input  logic              clear,
    output logic              serial_out,
    output logic              last_bit
);

    localparam int BC_W = (WORD_W > 1) ? $clog2(WORD_W) : 1;

    logic [WORD_W-1:0] sreg_q;
    logic [BC_W-1:0]   bit_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q    <= '0;
            bit_cnt_q <= '0;
        end else if (load) begin
            sreg_q    <= word;
            bit_cnt_q <= '0;
        end else if (shift) begin
            sreg_q    <= {sreg_q[WORD_W-2:0], 1'b0};
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (clear) begin
            sreg_q    <= '0;
            bit_cnt_q <= '0;
        end
    end

    assign serial_out = sreg_q[WORD_W-1];
    assign last_bit   = (bit_cnt_q == BC_W'(WORD_W - 1));

endmodule

// File: rtl/tbm_sel_decode.sv
module tbm_sel_decode #(
    parameter int NUM_DEV = 3,
    parameter int DEV_W   = 2
) (
    input  logic               en,
    input  logic [DEV_W-1:0]   idx,
    output logic [NUM_DEV-1:0] sel
);

    for (genvar g = 0; g < NUM_DEV; g++) begin : g_line
        assign sel[g] = en && (idx == DEV_W'(g));
    end

endmodule

// File: rtl/tune_bus_master.sv
module tune_bus_master
    import tbm_pkg::*;
#(
    parameter int NUM_DEV   = 3,
    parameter int DEV_W     = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
    parameter int HALF_CYC  = 4,
    parameter int LEAD_CYC  = 4,
    parameter int TRAIL_CYC = 2,
    parameter int GAP_CYC   = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [DEV_W-1:0]   req_dev,
    input  logic [4:0]         req_state,
    input  logic               req_standby,
    output logic               bus_sclk,
    output logic               bus_sdata,
    output logic [NUM_DEV-1:0] bus_sen
);

    localparam int MAX_CYC = max4(HALF_CYC, LEAD_CYC, TRAIL_CYC, GAP_CYC);
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    tbm_state_e state_q, state_nx;

    logic             tmr_expired;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             last_bit;
    logic             accept;
    logic             active_nx;
    logic [DEV_W-1:0] dev_q, dev_nx;
    logic [NUM_DEV-1:0] sel_nx;
    logic             sh_shift, sh_clear;
    logic             sclk_q;
    logic [NUM_DEV-1:0] sen_q;

    assign accept = (state_q == ST_IDLE) && req_valid;

    // Next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid)   state_nx = ST_LEAD;
            ST_LEAD:   if (tmr_expired) state_nx = ST_SCK_HI;
            ST_SCK_HI: if (tmr_expired) state_nx = last_bit ? ST_TAIL : ST_SCK_LO;
            ST_SCK_LO: if (tmr_expired) state_nx = ST_SCK_HI;
            ST_TAIL:   if (tmr_expired) state_nx = ST_GAP;
            ST_GAP:    if (tmr_expired) state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // Phase length for the state being entered
    always_comb begin
        tmr_load = (state_nx != state_q);
        unique case (state_nx)
            ST_LEAD:   tmr_val = CNT_W'(LEAD_CYC);
            ST_SCK_HI: tmr_val = CNT_W'(HALF_CYC);
            ST_SCK_LO: tmr_val = CNT_W'(HALF_CYC);
            ST_TAIL:   tmr_val = CNT_W'(TRAIL_CYC);
            ST_GAP:    tmr_val = CNT_W'(GAP_CYC);
            default:   tmr_val = CNT_W'(1);
        endcase
    end

    tbm_phase_timer #(.CNT_W(CNT_W)) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    assign sh_shift = (state_q == ST_SCK_HI) && (state_nx == ST_SCK_LO);
    assign sh_clear = (state_q == ST_TAIL)   && (state_nx == ST_GAP);

    tbm_word_shifter #(.WORD_W(WORD_W)) shifter_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (accept),
        .word       (build_word(req_standby, req_state)),
        .shift      (sh_shift),
        .clear      (sh_clear),
        .serial_out (bus_sdata),
        .last_bit   (last_bit)
    );

    // Target index held for the whole transfer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dev_q <= '0;
        else if (accept) dev_q <= req_dev;
    end

    assign dev_nx    = accept ? req_dev : dev_q;
    assign active_nx = (state_nx == ST_LEAD) || (state_nx == ST_SCK_HI) ||
                       (state_nx == ST_SCK_LO) || (state_nx == ST_TAIL);

    tbm_sel_decode #(.NUM_DEV(NUM_DEV), .DEV_W(DEV_W)) decode_i (
        .en  (active_nx),
        .idx (dev_nx),
        .sel (sel_nx)
    );

    // Output register process: pins follow the state being entered
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            sen_q  <= '0;
        end else begin
            sclk_q <= (state_nx == ST_SCK_HI);
            sen_q  <= sel_nx;
        end
    end

    assign bus_sclk  = sclk_q;
    assign bus_sen   = sen_q;
    assign req_ready = (state_q == ST_IDLE);

endmodule

// File: rtl/tune_bus_master_chk.sv
module tune_bus_master_chk #(
    parameter int NUM_DEV   = 3,
    parameter int HALF_CYC  = 4,
    parameter int LEAD_CYC  = 4,
    parameter int TRAIL_CYC = 2,
    parameter int GAP_CYC   = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic               bus_sclk,
    input logic               bus_sdata,
    input logic [NUM_DEV-1:0] bus_sen
);

    logic        any_sen;
    logic        sclk_d;
    logic [15:0] sen_hi_age, sen_lo_age, since_rise, hi_len, lo_len;

    assign any_sen = |bus_sen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d     <= 1'b0;
            sen_hi_age <= '0;
            sen_lo_age <= '1;
            since_rise <= '0;
            hi_len     <= '0;
            lo_len     <= '0;
        end else begin
            sclk_d     <= bus_sclk;
            sen_hi_age <= !any_sen ? '0 : ((sen_hi_age != '1) ? sen_hi_age + 1'b1 : sen_hi_age);
            sen_lo_age <= any_sen  ? '0 : ((sen_lo_age != '1) ? sen_lo_age + 1'b1 : sen_lo_age);
            since_rise <= (bus_sclk && !sclk_d) ? 16'd1 :
                          ((since_rise != '1) ? since_rise + 1'b1 : since_rise);
            hi_len     <= !bus_sclk ? '0 : ((hi_len != '1) ? hi_len + 1'b1 : hi_len);
            lo_len     <= bus_sclk  ? '0 : ((lo_len != '1) ? lo_len + 1'b1 : lo_len);
        end
    end

    AST_SEN_ONEHOT:  assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bus_sen));                                                   // R1
    AST_DATA_STILL:  assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sclk && sclk_d) |-> $stable(bus_sdata));                         // R3
    AST_HIGH_WIDTH:  assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_sclk && sclk_d) |-> (hi_len == 16'(HALF_CYC)));                 // R4
    AST_LOW_WIDTH:   assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sclk && !sclk_d && any_sen && sen_hi_age > 16'(LEAD_CYC))
            |-> (lo_len == 16'(HALF_CYC)));                                   // R4
    AST_LEAD_TIME:   assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sclk && !sclk_d && any_sen) |-> (sen_hi_age >= 16'(LEAD_CYC)));  // R5
    AST_TRAIL_TIME:  assert property (@(posedge clk) disable iff (!rst_n)
        $fell(any_sen) |-> (since_rise == 16'(HALF_CYC + TRAIL_CYC)));        // R6
    AST_WORD_GAP:    assert property (@(posedge clk) disable iff (!rst_n)
        $rose(any_sen) |-> (sen_lo_age >= 16'(GAP_CYC)));                     // R7
    AST_READY_DROP:  assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);                             // R8
    AST_IDLE_QUIET:  assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!bus_sclk && !bus_sdata && !any_sen));                 // R9

endmodule

bind tune_bus_master tune_bus_master_chk #(
    .NUM_DEV   (NUM_DEV),
    .HALF_CYC  (HALF_CYC),
    .LEAD_CYC  (LEAD_CYC),
    .TRAIL_CYC (TRAIL_CYC),
    .GAP_CYC   (GAP_CYC)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .bus_sclk  (bus_sclk),
    .bus_sdata (bus_sdata),
    .bus_sen   (bus_sen)
);

// File: tb/tune_bus_master_tb_top.sv
`timescale 1ns/1ps
module tune_bus_master_tb_top;

    localparam int NDEV  = 3;
    localparam int DW    = 2;
    localparam int H     = 4;
    localparam int L     = 5;
    localparam int T     = 3;
    localparam int G     = 9;
    localparam int FALL_T  = L + 15*H + T + 1;
    localparam int READY_T = FALL_T + G;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic [DW-1:0]   req_dev = '0;
    logic [4:0]      req_state = '0;
    logic            req_standby = 1'b0;
    logic            bus_sclk, bus_sdata;
    logic [NDEV-1:0] bus_sen;

    int n_cmp = 0;
    int n_bad = 0;
    int fall_log[$];

    always #2.5 clk = ~clk;

    tune_bus_master #(
        .NUM_DEV(NDEV), .DEV_W(DW), .HALF_CYC(H),
        .LEAD_CYC(L), .TRAIL_CYC(T), .GAP_CYC(G)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_dev(req_dev), .req_state(req_state), .req_standby(req_standby),
        .bus_sclk(bus_sclk), .bus_sdata(bus_sdata), .bus_sen(bus_sen)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One transfer; entered and left at a falling clock edge.
    task automatic run_xfer(input int dev, input int st, input int sb);
        int t, rises, first_rise, last_rise, sen_fall, hi_cyc, per_bad;
        logic [7:0] word, exp_word;
        logic prev_sclk, prev_data;
        logic [NDEV-1:0] prev_sen;
        bit sen_bad, sen_seen, data_bad;
        bit valid_dev;
        valid_dev = (dev < NDEV);
        exp_word  = {2'b00, sb[0], st[4:0]};
        req_dev = DW'(dev); req_state = st[4:0]; req_standby = sb[0]; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R8 ready low after accept", req_ready, 0);
        t = 1; rises = 0; first_rise = -1; last_rise = -1; sen_fall = -1;
        hi_cyc = 0; per_bad = 0; word = '0;
        prev_sclk = 1'b0; prev_data = bus_sdata; prev_sen = '0;
        sen_bad = 0; sen_seen = 0; data_bad = 0;
        while (!req_ready && t < 2000) begin
            if (bus_sclk && !prev_sclk) begin
                rises++;
                word = {word[6:0], bus_sdata};
                if (last_rise >= 0 && (t - last_rise) != 2*H) per_bad++;
                if (first_rise < 0) first_rise = t;
                last_rise = t;
            end
            if (bus_sclk && prev_sclk && (bus_sdata != prev_data)) data_bad = 1;
            if (bus_sclk) hi_cyc++;
            if (bus_sen != '0) begin
                sen_seen = 1;
                if (!valid_dev || bus_sen != NDEV'(1 << dev)) sen_bad = 1;
            end
            if (prev_sen != '0 && bus_sen == '0) begin
                sen_fall = t;
                fall_log.push_back(dev);
            end
            prev_sclk = bus_sclk; prev_data = bus_sdata; prev_sen = bus_sen;
            @(negedge clk);
            t++;
        end
        chk(rises == 8, "R2 rising edge count", rises, 8);
        chk(word == exp_word, "R2 shifted word", word, exp_word);
        chk(!data_bad, "R3 data still while clock high", data_bad, 0);
        chk(hi_cyc == 8*H && per_bad == 0, "R4 phase widths", hi_cyc, 8*H);
        chk(first_rise == L + 1, "R5 lead to first rise", first_rise, L + 1);
        chk(t == READY_T, "R7 ready return time", t, READY_T);
        chk(!bus_sclk && !bus_sdata && bus_sen == '0, "R9 quiet when ready",
            {bus_sclk, bus_sdata, bus_sen}, 0);
        if (valid_dev) begin
            chk(sen_seen && !sen_bad, "R1 only addressed enable", sen_bad, 0);
            chk(sen_fall - last_rise == H + T, "R6 last rise to enable fall",
                sen_fall - last_rise, H + T);
            chk(READY_T - sen_fall == G, "R7 gap after enable fall", READY_T - sen_fall, G);
        end else begin
            chk(!sen_seen, "R10 no enable for out-of-range index", sen_seen, 0);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        int seq[3];
        repeat (4) @(negedge clk);
        chk(!bus_sclk && !bus_sdata && bus_sen == '0, "R9 reset outputs",
            {bus_sclk, bus_sdata, bus_sen}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, "R8 ready after reset", req_ready, 1);

        // Valid low: nothing may start.
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (bus_sen != '0 || bus_sclk || !req_ready) begin
                chk(0, "R8 idle without valid", {bus_sen, bus_sclk}, 0);
            end
        end
        chk(req_ready && bus_sen == '0, "R8 no transfer without valid", bus_sen, 0);

        // Sweep every device, state and standby value.
        for (int d = 0; d < NDEV; d++)
            for (int s = 0; s < 32; s++)
                for (int b = 0; b < 2; b++)
                    run_xfer(d, s, b);

        // Out-of-range index.
        run_xfer(3, 5'h15, 0);
        run_xfer(3, 5'h0A, 1);

        // Sequential commits in request order.
        fall_log.delete();
        seq = '{2, 0, 1};
        foreach (seq[k]) run_xfer(seq[k], 7 + k, k & 1);
        chk(fall_log.size() == 3, "R11 commit count", fall_log.size(), 3);
        foreach (seq[k]) begin
            if (k < fall_log.size())
                chk(fall_log[k] == seq[k], "R11 commit order", fall_log[k], seq[k]);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule